// File: doc/BRIEF.md
# SPI Bit-Clock Prescaler

This block derives the serial bit-clock timing of an SPI controller from the core clock. Software writes an 8-bit prescale byte. The block decodes that byte into a divisor and then produces two outputs. The first is a single-cycle `half_tick` pulse that marks the end of every half period of the serial clock. The second is `sclk_level`, the idle-low level of the serial clock that those pulses toggle. A shift engine next to the block uses the pulses to move data bits and the level to drive its clock pin.

A parameter selects one of two byte formats. The legacy format gives even divisors up to 30. The split format multiplies a 4-bit mantissa by a power of two, and the exponent bits of that power are spread over the byte, which allows divisors up to 1920. The prescale byte is sampled only when `run` rises. While `run` stays high the divisor cannot change, so a word in flight never sees a glitch. Dropping `run` parks the clock low and resets its phase. There is no data stream through the block, so every pin is a plain level or pulse with no valid/ready handshake.

Top module: `spi_clk_prescaler`

## Requirements
- R1: Legacy format: for a byte whose bits [4:0] hold a value f from 18 to 31, the divisor is 2*(f-16). This gives the even divisors 4 through 30.
- R2: Legacy format: a value of bits [4:0] below 18 gives divisor 4.
- R3: Split format: the mantissa is bits [3:0] (1 to 15). The exponent is {bit 7, bit 6, bit 4}, with bit 4 as its least significant bit. The divisor is mantissa shifted left by the exponent, so the largest is 1920. A computed divisor of 1 is raised to 2.
- R4: Bit 5 of the prescale byte never affects the result. In the legacy format, bits 7 and 6 do not affect it either.
- R5: Split format with mantissa 0: once it is captured, `cfg_err` is 1, `divisor` is 0, and `half_tick` and `sclk_level` stay 0 for as long as `run` is high.
- R6: For divisor d, the first cycle after the clock edge that samples `run` rising starts a low phase of ceil(d/2) cycles. A high phase of floor(d/2) cycles follows, and the pattern repeats. `half_tick` is 1 in the last cycle of each phase, and `sclk_level` is 1 during high phases.
- R7: The byte is captured only at a rising edge of `run`. Changes while `run` stays high have no effect on `divisor`, `cfg_err`, `half_tick` or `sclk_level`.
- R8: From the first clock edge that samples `run` low, `half_tick` and `sclk_level` are 0. The next rise of `run` starts again at the beginning of a low phase.
- R9: After reset, `half_tick`, `sclk_level`, `divisor` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous reset, active low |
| run | input | 1 | high keeps the clock running; a rising edge captures the prescale byte |
| prescale_cfg | input | 8 | prescale byte in the format chosen by FORMAT |
| half_tick | output | 1 | one-cycle pulse at the end of each half period |
| sclk_level | output | 1 | serial clock level, idle low |
| divisor | output | DIV_W | divisor captured at the last rise of run |
| cfg_err | output | 1 | captured byte has mantissa 0 (split format only) |

## Verification
The hardest case to reach is a change to the prescale byte while a long division is in progress. It only matters if the bench keeps `run` high across a phase boundary and then compares the waveform against the divisor that was captured, not against the new byte. The bench sets up this case directly: in the middle of several windows it flips mantissa and exponent bits, then keeps comparing every cycle against the original divisor. Odd divisors, divisor 2, the 1920 maximum and mantissa 0 are run as directed cases. Seeded random bytes cover the remaining exponent positions in both formats.

// File: rtl/spi_pre_pkg.sv
package spi_pre_pkg;

  typedef enum logic {
    FMT_LEGACY = 1'b0,
    FMT_SPLIT  = 1'b1
  } fmt_e;

  localparam int CFG_W     = 8;
  localparam int MANT_W    = 4;
  localparam int EXP_W     = 3;
  localparam int LEG_W     = 5;
  localparam int LEG_BASE  = 16;
  localparam int LEG_FLOOR = 4;

  // exponent bits sit at byte positions 7,6 (upper) and 4 (lsb)
  function automatic logic [EXP_W-1:0] split_exp(input logic [CFG_W-1:0] b);
    return {b[7], b[6], b[4]};
  endfunction

endpackage

// File: rtl/spi_pre_decode.sv
module spi_pre_decode
  import spi_pre_pkg::*;
#(
  parameter fmt_e FORMAT = FMT_SPLIT,
  parameter int   DIV_W  = 11
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [DIV_W-1:0] div,
  output logic             err
);

  generate
    if (FORMAT == FMT_SPLIT) begin : g_split
      logic [MANT_W-1:0] mant;
      logic [EXP_W-1:0]  expo;
      logic [DIV_W-1:0]  raw;

      always_comb begin
        mant = cfg[MANT_W-1:0];
        expo = split_exp(cfg);
        raw  = DIV_W'(mant) << expo;
        err  = (mant == '0);
        if (raw == DIV_W'(1)) div = DIV_W'(2);
        else                  div = raw;
      end
    end else begin : g_legacy
      logic [LEG_W-1:0] fld;

      always_comb begin
        fld = cfg[LEG_W-1:0];
        err = 1'b0;
        if (fld >= LEG_W'(LEG_BASE + LEG_FLOOR/2))
          div = DIV_W'({fld[LEG_W-2:0], 1'b0});
        else
          div = DIV_W'(LEG_FLOOR);
      end
    end
  endgenerate

endmodule

// File: rtl/spi_pre_capture.sv
module spi_pre_capture
  import spi_pre_pkg::*;
#(
  parameter fmt_e FORMAT = FMT_SPLIT,
  parameter int   DIV_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  input  logic             err_in,
  output logic             start,
  output logic [DIV_W-1:0] div_q,
  output logic             err_q
);

  localparam int MAX_DIV = (FORMAT == FMT_SPLIT) ?
                           (((1 << MANT_W) - 1) << ((1 << EXP_W) - 1)) :
                           2 * ((1 << (LEG_W - 1)) - 1);

  logic run_q;

  assign start = run & ~run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      div_q <= '0;
      err_q <= 1'b0;
    end else begin
      run_q <= run;
      if (start) begin
        div_q <= div_in;
        err_q <= err_in;
      end
    end
  end

  // R7: no recapture while run stays high
  a_r7_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (run && run_q) |=> ($stable(div_q) && $stable(err_q)));

  // R3: captured divisor never exceeds the format maximum
  a_r3_div_cap: assert property (@(posedge clk) disable iff (!rst_n)
    {21'd0, div_q} <= 32'(MAX_DIV));

endmodule

// File: rtl/spi_pre_phase.sv
module spi_pre_phase #(
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic [DIV_W-1:0] div_q,
  input  logic             err_q,
  output logic             tick,
  output logic             level
);

  localparam int CNT_W = DIV_W - 1;

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] lo_len, hi_len, cur_len;
  logic             last;

  always_comb begin
    lo_len  = (div_q + DIV_W'(1)) >> 1;
    hi_len  = div_q >> 1;
    cur_len = level ? hi_len : lo_len;
    last    = ({1'b0, cnt} == (cur_len - DIV_W'(1)));
  end

  assign tick = active & ~err_q & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      level  <= 1'b0;
    end else if (!run) begin
      active <= 1'b0;
      cnt    <= '0;
      level  <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      level  <= 1'b0;
    end else if (active && !err_q) begin
      if (last) begin
        cnt   <= '0;
        level <= ~level;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R8: released run parks the clock
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!tick && !level));

  // R5: invalid capture keeps the clock silent
  a_r5_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!tick && !level));

  // R6: each tick flips the level at the next edge
  a_r6_tick_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run) |=> (level != $past(level)));

  // R6: count stays inside the current phase
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !err_q) |-> ({1'b0, cnt} < cur_len));

endmodule

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler
  import spi_pre_pkg::*;
#(
  parameter fmt_e FORMAT = FMT_SPLIT,
  parameter int   DIV_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [7:0]       prescale_cfg,
  output logic             half_tick,
  output logic             sclk_level,
  output logic [DIV_W-1:0] divisor,
  output logic             cfg_err
);

  logic [DIV_W-1:0] dec_div;
  logic             dec_err;
  logic             start;

  spi_pre_decode #(.FORMAT(FORMAT), .DIV_W(DIV_W)) u_decode (
    .cfg (prescale_cfg),
    .div (dec_div),
    .err (dec_err)
  );

  spi_pre_capture #(.FORMAT(FORMAT), .DIV_W(DIV_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .div_in (dec_div),
    .err_in (dec_err),
    .start  (start),
    .div_q  (divisor),
    .err_q  (cfg_err)
  );

  spi_pre_phase #(.DIV_W(DIV_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .start (start),
    .div_q (divisor),
    .err_q (cfg_err),
    .tick  (half_tick),
    .level (sclk_level)
  );

endmodule

// File: tb/test_spi_clk_prescaler.sv
`timescale 1ns/100ps
module test_spi_clk_prescaler;
  import spi_pre_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_e = 1'b0, run_l = 1'b0;
  logic [7:0]  cfg_e = 8'h00, cfg_l = 8'h00;
  logic        tk_e, lv_e, er_e, tk_l, lv_l, er_l;
  logic [10:0] dv_e, dv_l;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  spi_clk_prescaler #(.FORMAT(FMT_SPLIT), .DIV_W(11)) i_spi_clk_prescaler (
    .clk(clk), .rst_n(rst_n), .run(run_e), .prescale_cfg(cfg_e),
    .half_tick(tk_e), .sclk_level(lv_e), .divisor(dv_e), .cfg_err(er_e));

  spi_clk_prescaler #(.FORMAT(FMT_LEGACY), .DIV_W(11)) i_spi_clk_prescaler_leg (
    .clk(clk), .rst_n(rst_n), .run(run_l), .prescale_cfg(cfg_l),
    .half_tick(tk_l), .sclk_level(lv_l), .divisor(dv_l), .cfg_err(er_l));

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int exp_div(input bit ext, input logic [7:0] b);
    int d;
    if (ext) begin
      d = int'(b[3:0]) << int'({b[7], b[6], b[4]});
      if (d == 1) d = 2;
    end else begin
      d = (int'(b[4:0]) >= 18) ? 2 * (int'(b[4:0]) - 16) : 4;
    end
    return d;
  endfunction

  function automatic bit exp_err(input bit ext, input logic [7:0] b);
    return ext && (b[3:0] == 4'd0);
  endfunction

  task automatic run_case(input bit ext, input logic [7:0] b,
                          input string tag, input bit mid);
    int  d, lo, cyc, mism, fk, m;
    bit  e, et, el, at, al, ft, fl, fat, fal;
    d   = exp_div(ext, b);
    e   = exp_err(ext, b);
    lo  = (d + 1) / 2;
    cyc = e ? 12 : 2 * d + 4;
    mism = 0; fk = 0; ft = 0; fl = 0; fat = 0; fal = 0;
    @(negedge clk);
    if (ext) begin cfg_e = b; run_e = 1'b1; end
    else     begin cfg_l = b; run_l = 1'b1; end
    for (int j = 1; j <= cyc; j++) begin
      @(negedge clk);
      if (mid && j == cyc / 2) begin
        if (ext) cfg_e = b ^ 8'h5B; else cfg_l = b ^ 8'h0B;
      end
      if (e) begin et = 1'b0; el = 1'b0; end
      else begin
        m  = (j - 1) % d;
        et = (m == lo - 1) || (m == d - 1);
        el = (m >= lo);
      end
      at = ext ? tk_e : tk_l;
      al = ext ? lv_e : lv_l;
      if (at != et || al != el) begin
        if (mism == 0) begin fk = j - 1; ft = et; fl = el; fat = at; fal = al; end
        mism++;
      end
      if (j == 1) begin
        chk((ext ? dv_e : dv_l) == 11'(e ? 0 : d),
            $sformatf("%s divisor cfg=%h got=%0d exp=%0d", tag, b,
                      ext ? dv_e : dv_l, e ? 0 : d));
        chk((ext ? er_e : er_l) == e,
            $sformatf("%s cfg_err cfg=%h got=%b exp=%b", tag, b,
                      ext ? er_e : er_l, e));
      end
    end
    chk(mism == 0, $sformatf("%s waveform cfg=%h k=%0d tick=%b/%b level=%b/%b (got/exp)",
                             mid ? "R7" : (e ? "R5" : "R6"), b, fk, fat, ft, fal, fl));
    if (mid)
      chk((ext ? dv_e : dv_l) == 11'(e ? 0 : d),
          $sformatf("R7 divisor after change got=%0d exp=%0d",
                    ext ? dv_e : dv_l, e ? 0 : d));
    if (ext) run_e = 1'b0; else run_l = 1'b0;
    @(negedge clk);
    chk(((ext ? tk_e : tk_l) == 1'b0) && ((ext ? lv_e : lv_l) == 1'b0),
        $sformatf("R8 release tick=%b level=%b exp=0/0",
                  ext ? tk_e : tk_l, ext ? lv_e : lv_l));
    @(negedge clk);
  endtask

  initial begin
    int unsigned sd;
    logic [7:0] rb;
    sd = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!tk_e && !lv_e && dv_e == 0 && !er_e && !tk_l && !lv_l && dv_l == 0 && !er_l,
        $sformatf("R9 reset tick=%b level=%b div=%0d err=%b exp=0", tk_e, lv_e, dv_e, er_e));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tk_e && !lv_e && dv_e == 0 && !er_e,
        $sformatf("R9 after reset tick=%b level=%b div=%0d err=%b exp=0", tk_e, lv_e, dv_e, er_e));

    // split format directed
    run_case(1'b1, 8'h01, "R3", 1'b0);   // divisor 1 raised to 2
    run_case(1'b1, 8'h03, "R3", 1'b0);   // odd divisor 3
    run_case(1'b1, 8'h45, "R3", 1'b0);   // 5 << 2 = 20
    run_case(1'b1, 8'h65, "R4", 1'b0);   // same as 0x45, bit 5 set
    run_case(1'b1, 8'hDF, "R3", 1'b0);   // 1920 maximum
    run_case(1'b1, 8'hFF, "R4", 1'b0);   // maximum with bit 5 set
    run_case(1'b1, 8'h50, "R5", 1'b0);   // mantissa 0
    run_case(1'b1, 8'h97, "R7", 1'b1);   // change mid-run
    run_case(1'b1, 8'h13, "R7", 1'b1);
    // legacy directed
    run_case(1'b0, 8'h00, "R2", 1'b0);
    run_case(1'b0, 8'h11, "R2", 1'b0);
    run_case(1'b0, 8'h12, "R1", 1'b0);
    run_case(1'b0, 8'h1F, "R1", 1'b0);
    run_case(1'b0, 8'hFF, "R4", 1'b0);   // bits 7:5 ignored
    run_case(1'b0, 8'h17, "R1", 1'b0);   // odd field -> even divisor 14
    run_case(1'b0, 8'h1A, "R7", 1'b1);
    // seeded random
    for (int i = 0; i < 20; i++) begin
      rb = 8'($urandom);
      run_case(1'b1, rb, (rb[3:0] == 0) ? "R5" : "R3", (i % 4) == 3);
    end
    for (int i = 0; i < 10; i++) begin
      rb = 8'($urandom);
      run_case(1'b0, rb, (rb[4:0] < 5'd18) ? "R2" : "R1", 1'b0);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule